// File: doc/BRIEF.md
# Receive Character FIFO with Fill Trigger and Idle Timeout

This block buffers characters coming out of a UART receive shifter until the host collects them. Each stored entry carries the 8-bit character together with its parity-error, framing-error and break flags, so that an error is reported when the host is about to read the character it belongs to, not when it arrives. The host sees the character at the head of the queue, its three flags, a data-ready bit, an overrun bit and a bit saying that some queued character is flagged.

Two interrupt causes are derived from the queue. The data-available request is raised while the fill level is at or above a threshold picked by a 2-bit field. The idle-timeout request is raised when characters are waiting but nothing has been stored or removed for four character times, which are counted from a tick supplied by the baud-rate logic. A control write enables or disables the queue, loads the threshold, and can empty the queue in one cycle. The serial deserializer and the register decoder sit outside this block.

Top module: `rx_char_fifo`

## Requirements
- R1: After reset the queue is empty and disabled, the threshold selection is 00, and every output is 0.
- R2: A control write always loads the enable bit. When that bit is 1 the same write also loads the threshold field. When it is 0 the queue is emptied and characters that arrive are dropped without being counted until a later write sets enable to 1.
- R3: Accepted characters come out at the head in arrival order. A host read removes the head character. A host read of an empty queue has no effect. headData is 0 while the queue is empty.
- R4: The threshold field sets the level: 00 selects 1, 01 selects 4, 10 selects 8 and 11 selects 14 characters. rxAvailIrq is 1 exactly while the stored count is at or above that level.
- R5: dataReady is 1 exactly while at least one character is stored.
- R6: If a character arrives while all 16 entries are full and no read happens in the same cycle, it is dropped, the stored contents stay as they were, and overrun becomes 1. Overrun returns to 0 on a line-status read. A character that arrives together with a read of a full queue is accepted.
- R7: headParErr, headFrmErr and headBrk show the flags stored with the head character only. They are 0 while the queue is empty.
- R8: fifoErr is 1 while any stored character carries a flag, unless a line-status read has come since the last flagged character was accepted. It drops to 0 once no stored character is flagged.
- R9: timeoutIrq becomes 1 after four character ticks during which the queue was non-empty and nothing was stored or removed. Any store, removal or emptying restarts the count from zero.
- R10: A control write with enable 1 and the flush bit set empties the queue in that cycle. The flush takes effect once, and later characters are accepted as normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| charValid | input | 1 | One-cycle strobe: a character is complete |
| charData | input | 8 | Completed character |
| charParErr | input | 1 | Parity error for the completed character |
| charFrmErr | input | 1 | Framing error for the completed character |
| charBrk | input | 1 | Break flag for the completed character |
| dataRead | input | 1 | Host read of the receive data |
| lsrRead | input | 1 | Host read of line status |
| ctlWrite | input | 1 | Control register write strobe |
| ctlEnable | input | 1 | Enable bit of the control write |
| ctlFlush | input | 1 | Flush bit of the control write |
| ctlTrig | input | 2 | Threshold selection of the control write |
| charTick | input | 1 | One pulse per character time |
| headData | output | 8 | Character at the head of the queue |
| headParErr | output | 1 | Parity flag of the head character |
| headFrmErr | output | 1 | Framing flag of the head character |
| headBrk | output | 1 | Break flag of the head character |
| dataReady | output | 1 | Queue is not empty |
| overrun | output | 1 | A character was dropped because the queue was full |
| fifoErr | output | 1 | A stored character carries a flag |
| rxAvailIrq | output | 1 | Fill level is at or above the threshold |
| timeoutIrq | output | 1 | Characters are waiting and the queue has been idle |

## Verification
A read pointer that is off by one shows at headData and at the head flags on the first read after the fault. A wrong occupancy count shows within one cycle at dataReady or rxAvailIrq near a threshold, and at overrun when the 17th character arrives. An error counter that falls out of step with the stored flags keeps fifoErr high after the last flagged character has been read, or leaves it low when one arrives. A wrong idle counter makes timeoutIrq rise one tick early or late, or fail to clear on a read. Each of these faults therefore appears at the ports within a few cycles of the event that exposes it.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;

  // One queue entry: the character and the three flags stored with it.
  typedef struct packed {
    logic       brk;
    logic       frm;
    logic       par;
    logic [7:0] data;
  } rxEntry_t;

  // Strobes sent from the control to the datapath.
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } fifoStrobe_t;

  // Fill level selected by the 2-bit threshold field.
  function automatic int trigLevel(input logic [1:0] sel, input int depth);
    case (sel)
      2'b00:   return 1;
      2'b01:   return depth / 4;
      2'b10:   return depth / 2;
      default: return depth - 2;
    endcase
  endfunction

endpackage

// File: rtl/rx_fifo_dp.sv
module rx_fifo_dp
  import rx_fifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  fifoStrobe_t              strobe,
  input  rxEntry_t                 wrEntry,
  output rxEntry_t                 headEntry,
  output logic [$clog2(DEPTH):0]   level,
  output logic                     errPresent
);

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int CNT_W  = ADDR_W + 1;

  rxEntry_t              mem [DEPTH];
  logic [ADDR_W-1:0]     wrPtr;
  logic [ADDR_W-1:0]     rdPtr;
  logic [CNT_W-1:0]      errCount;
  logic                  pushErr;
  logic                  popErr;

  assign pushErr = strobe.push && (wrEntry.par || wrEntry.frm || wrEntry.brk);
  assign popErr  = strobe.pop && (mem[rdPtr].par || mem[rdPtr].frm || mem[rdPtr].brk);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      level    <= '0;
      errCount <= '0;
    end else if (strobe.flush) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      level    <= '0;
      errCount <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrPtr + ADDR_W'(1);
      if (strobe.pop)  rdPtr <= rdPtr + ADDR_W'(1);
      level    <= level + CNT_W'(strobe.push) - CNT_W'(strobe.pop);
      errCount <= errCount + CNT_W'(pushErr) - CNT_W'(popErr);
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= wrEntry;
  end

  assign headEntry  = (level != '0) ? mem[rdPtr] : '0;
  assign errPresent = (errCount != '0);

  // R6: the count never exceeds the storage
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    level <= CNT_W'(DEPTH));

  // R3: a removal is only issued when data is stored
  a_r3_pop_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> level != '0);

  // R8: flagged entries are a subset of stored entries
  a_r8_err_bounded: assert property (@(posedge clk) disable iff (!rstN)
    errCount <= level);

endmodule

// File: rtl/rx_fifo_ctrl.sv
module rx_fifo_ctrl
  import rx_fifo_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int TO_CHARS = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     charValid,
  input  logic                     charHasErr,
  input  logic                     dataRead,
  input  logic                     lsrRead,
  input  logic                     ctlWrite,
  input  logic                     ctlEnable,
  input  logic                     ctlFlush,
  input  logic [1:0]               ctlTrig,
  input  logic                     charTick,
  input  logic [$clog2(DEPTH):0]   level,
  input  logic                     errPresent,
  output fifoStrobe_t              strobe,
  output logic                     dataReady,
  output logic                     overrun,
  output logic                     fifoErr,
  output logic                     rxAvailIrq,
  output logic                     timeoutIrq
);

  localparam int CNT_W = $clog2(DEPTH) + 1;
  localparam int TO_W  = $clog2(TO_CHARS + 1);

  logic            fifoOn;
  logic [1:0]      trigSel;
  logic            errAck;
  logic [TO_W-1:0] idleCnt;
  logic            flushNow;
  logic            popOk;
  logic            pushOk;
  logic            dropChar;
  logic            isFull;
  logic [CNT_W-1:0] threshold;

  assign isFull   = (level == CNT_W'(DEPTH));
  assign flushNow = ctlWrite && (!ctlEnable || ctlFlush);
  assign popOk    = dataRead && (level != '0) && !flushNow;
  assign pushOk   = charValid && fifoOn && !flushNow && (!isFull || popOk);
  assign dropChar = charValid && fifoOn && !flushNow && isFull && !popOk;

  always_comb begin
    strobe.push  = pushOk;
    strobe.pop   = popOk;
    strobe.flush = flushNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoOn  <= 1'b0;
      trigSel <= 2'b00;
      overrun <= 1'b0;
      errAck  <= 1'b0;
      idleCnt <= '0;
    end else begin
      if (ctlWrite) fifoOn <= ctlEnable;
      if (ctlWrite && ctlEnable) trigSel <= ctlTrig;

      if (dropChar)     overrun <= 1'b1;
      else if (lsrRead) overrun <= 1'b0;

      if (flushNow)                   errAck <= 1'b0;
      else if (pushOk && charHasErr)  errAck <= 1'b0;
      else if (lsrRead)               errAck <= 1'b1;

      if (flushNow || pushOk || popOk || level == '0)
        idleCnt <= '0;
      else if (charTick && idleCnt != TO_W'(TO_CHARS))
        idleCnt <= idleCnt + TO_W'(1);
    end
  end

  assign threshold  = CNT_W'(trigLevel(trigSel, DEPTH));
  assign dataReady  = (level != '0);
  assign rxAvailIrq = (level >= threshold);
  assign fifoErr    = errPresent && !errAck;
  assign timeoutIrq = (idleCnt == TO_W'(TO_CHARS));

  // R6: a character arriving at a full queue with no read sets overrun
  a_r6_overrun_sets: assert property (@(posedge clk) disable iff (!rstN)
    (charValid && fifoOn && !ctlWrite && isFull && !dataRead) |=> overrun);

  // R6: the stored count is unchanged by the dropped character
  a_r6_full_unchanged: assert property (@(posedge clk) disable iff (!rstN)
    (charValid && fifoOn && !ctlWrite && isFull && !dataRead) |=> $stable(level));

  // R9: the idle request only appears with data waiting
  a_r9_timeout_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    timeoutIrq |-> level != '0);

  // R9: a read removes the idle request
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutIrq && dataRead && !ctlWrite) |=> !timeoutIrq);

  // R10: a flushing write empties the queue
  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrite && (!ctlEnable || ctlFlush)) |=> level == '0);

  // R4: the fill request implies data is present
  a_r4_irq_implies_ready: assert property (@(posedge clk) disable iff (!rstN)
    rxAvailIrq |-> dataReady);

endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo
  import rx_fifo_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int TO_CHARS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       charValid,
  input  logic [7:0] charData,
  input  logic       charParErr,
  input  logic       charFrmErr,
  input  logic       charBrk,
  input  logic       dataRead,
  input  logic       lsrRead,
  input  logic       ctlWrite,
  input  logic       ctlEnable,
  input  logic       ctlFlush,
  input  logic [1:0] ctlTrig,
  input  logic       charTick,
  output logic [7:0] headData,
  output logic       headParErr,
  output logic       headFrmErr,
  output logic       headBrk,
  output logic       dataReady,
  output logic       overrun,
  output logic       fifoErr,
  output logic       rxAvailIrq,
  output logic       timeoutIrq
);

  localparam int CNT_W = $clog2(DEPTH) + 1;

  fifoStrobe_t      strobe;
  rxEntry_t         wrEntry;
  rxEntry_t         headEntry;
  logic [CNT_W-1:0] level;
  logic             errPresent;

  assign wrEntry = '{brk: charBrk, frm: charFrmErr, par: charParErr, data: charData};

  rx_fifo_ctrl #(.DEPTH(DEPTH), .TO_CHARS(TO_CHARS)) ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .charValid  (charValid),
    .charHasErr (charParErr || charFrmErr || charBrk),
    .dataRead   (dataRead),
    .lsrRead    (lsrRead),
    .ctlWrite   (ctlWrite),
    .ctlEnable  (ctlEnable),
    .ctlFlush   (ctlFlush),
    .ctlTrig    (ctlTrig),
    .charTick   (charTick),
    .level      (level),
    .errPresent (errPresent),
    .strobe     (strobe),
    .dataReady  (dataReady),
    .overrun    (overrun),
    .fifoErr    (fifoErr),
    .rxAvailIrq (rxAvailIrq),
    .timeoutIrq (timeoutIrq)
  );

  rx_fifo_dp #(.DEPTH(DEPTH)) dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrEntry    (wrEntry),
    .headEntry  (headEntry),
    .level      (level),
    .errPresent (errPresent)
  );

  assign headData   = headEntry.data;
  assign headParErr = headEntry.par;
  assign headFrmErr = headEntry.frm;
  assign headBrk    = headEntry.brk;

endmodule

// File: tb/rx_char_fifo_test.sv
module rx_char_fifo_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       charValid = 0, charParErr = 0, charFrmErr = 0, charBrk = 0;
  logic [7:0] charData = 0;
  logic       dataRead = 0, lsrRead = 0, ctlWrite = 0, ctlEnable = 0, ctlFlush = 0;
  logic [1:0] ctlTrig = 0;
  logic       charTick = 0;
  logic [7:0] headData;
  logic       headParErr, headFrmErr, headBrk, dataReady, overrun, fifoErr, rxAvailIrq, timeoutIrq;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rx_char_fifo uut (.*);

  // reference state: {brk, frm, par, data}
  logic [10:0] mq[$];
  bit        mOn = 0;
  bit [1:0]  mTrig = 0;
  bit        mOvr = 0, mAck = 0;
  int        mIdle = 0;

  function automatic int lvlOf(bit [1:0] t);
    case (t) 2'd0: return 1; 2'd1: return 4; 2'd2: return 8; default: return 14; endcase
  endfunction

  function automatic int errEntries();
    int n = 0;
    foreach (mq[i]) if (mq[i][10:8] != 3'b000) n++;
    return n;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelStep();
    bit flush, pop, push, drop, full, hasErr;
    flush  = ctlWrite && (!ctlEnable || ctlFlush);
    pop    = dataRead && mq.size() != 0 && !flush;
    full   = mq.size() == 16;
    push   = charValid && mOn && !flush && (!full || pop);
    drop   = charValid && mOn && !flush && full && !pop;
    hasErr = charParErr || charFrmErr || charBrk;
    if (flush) mAck = 0; else if (push && hasErr) mAck = 0; else if (lsrRead) mAck = 1;
    if (flush || push || pop || mq.size() == 0) mIdle = 0;
    else if (charTick && mIdle != 4) mIdle++;
    if (drop) mOvr = 1; else if (lsrRead) mOvr = 0;
    if (flush) mq = {};
    else begin
      if (pop) void'(mq.pop_front());
      if (push) mq.push_back({charBrk, charFrmErr, charParErr, charData});
    end
    if (ctlWrite) mOn = ctlEnable;
    if (ctlWrite && ctlEnable) mTrig = ctlTrig;
  endtask

  task automatic checkAll();
    logic [10:0] h;
    h = (mq.size() != 0) ? mq[0] : 11'd0;
    chk("R3 headData", headData, h[7:0]);
    chk("R7 headParErr", headParErr, h[8]);
    chk("R7 headFrmErr", headFrmErr, h[9]);
    chk("R7 headBrk", headBrk, h[10]);
    chk("R5 dataReady", dataReady, mq.size() != 0);
    chk("R6 overrun", overrun, mOvr);
    chk("R8 fifoErr", fifoErr, errEntries() != 0 && !mAck);
    chk("R4 rxAvailIrq", rxAvailIrq, mq.size() >= lvlOf(mTrig));
    chk("R9 timeoutIrq", timeoutIrq, mIdle == 4);
  endtask

  task automatic clearIn();
    charValid = 0; charParErr = 0; charFrmErr = 0; charBrk = 0; charData = 0;
    dataRead = 0; lsrRead = 0; ctlWrite = 0; ctlEnable = 0; ctlFlush = 0;
    ctlTrig = 0; charTick = 0;
  endtask

  task automatic cycle();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    checkAll();
    clearIn();
  endtask

  task automatic ctl(input bit en, input bit fl, input bit [1:0] t);
    ctlWrite = 1; ctlEnable = en; ctlFlush = fl; ctlTrig = t;
    cycle();
  endtask

  task automatic pushChar(input bit [7:0] d, input bit [2:0] f);
    charValid = 1; charData = d; {charBrk, charFrmErr, charParErr} = f;
    cycle();
  endtask

  task automatic readChar();
    dataRead = 1;
    cycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 dataReady", dataReady, 0);
    chk("R1 rxAvailIrq", rxAvailIrq, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 fifoErr", fifoErr, 0);
    chk("R1 timeoutIrq", timeoutIrq, 0);
    chk("R1 headData", headData, 0);
    rstN = 1;
    @(negedge clk);

    // R2: queue disabled after reset drops characters
    pushChar(8'h11, 3'b000);
    chk("R2 drop while disabled", dataReady, 0);

    // R2/R4: enable with threshold 01 (level 4)
    ctl(1, 0, 2'b01);
    for (int i = 0; i < 3; i++) pushChar(8'h20 + 8'(i), 3'b000);
    chk("R4 below level 4", rxAvailIrq, 0);
    pushChar(8'h23, 3'b000);
    chk("R4 at level 4", rxAvailIrq, 1);
    readChar();
    chk("R4 falls below level 4", rxAvailIrq, 0);
    chk("R3 order after read", headData, 8'h21);

    // R10: flush bit empties, later characters accepted
    ctl(1, 1, 2'b01);
    chk("R10 flush empties", dataReady, 0);
    pushChar(8'h5A, 3'b000);
    chk("R10 accepted after flush", headData, 8'h5A);

    // R2: disabling write empties and drops
    ctl(0, 0, 2'b11);
    chk("R2 disable empties", dataReady, 0);
    pushChar(8'h66, 3'b000);
    chk("R2 drop after disable", dataReady, 0);
    ctl(1, 0, 2'b11);

    // R3: read of empty queue
    readChar();
    chk("R3 empty read", dataReady, 0);

    // R4/R6: fill to full with threshold 14
    for (int i = 0; i < 13; i++) pushChar(8'h80 + 8'(i), 3'b000);
    chk("R4 13 below level 14", rxAvailIrq, 0);
    pushChar(8'h8D, 3'b000);
    chk("R4 14 at level 14", rxAvailIrq, 1);
    pushChar(8'h8E, 3'b000);
    pushChar(8'h8F, 3'b000);
    chk("R6 not yet overrun", overrun, 0);
    pushChar(8'hEE, 3'b000);
    chk("R6 overrun on full", overrun, 1);
    chk("R6 head unchanged", headData, 8'h80);
    // R6: push with read at full is accepted
    charValid = 1; charData = 8'hC3; dataRead = 1;
    cycle();
    chk("R6 head after read", headData, 8'h81);
    lsrRead = 1;
    cycle();
    chk("R6 overrun cleared", overrun, 0);
    for (int i = 0; i < 15; i++) readChar();
    chk("R6 last char kept", headData, 8'hC3);
    readChar();

    // R7/R8: flags travel with characters
    pushChar(8'h01, 3'b000);
    pushChar(8'h02, 3'b001);
    pushChar(8'h03, 3'b110);
    chk("R7 head clean", headParErr, 0);
    chk("R8 fifoErr set", fifoErr, 1);
    lsrRead = 1;
    cycle();
    chk("R8 cleared by status read", fifoErr, 0);
    readChar();
    chk("R7 parity at head", headParErr, 1);
    pushChar(8'h04, 3'b100);
    chk("R8 set by new flagged char", fifoErr, 1);
    readChar();
    chk("R7 frame at head", headFrmErr, 1);
    chk("R7 break at head", headBrk, 1);
    readChar();
    readChar();
    chk("R8 clear when no flagged", fifoErr, 0);

    // R9: idle timeout
    pushChar(8'h77, 3'b000);
    for (int i = 0; i < 3; i++) begin charTick = 1; cycle(); end
    chk("R9 three ticks", timeoutIrq, 0);
    charTick = 1; cycle();
    chk("R9 four ticks", timeoutIrq, 1);
    readChar();
    chk("R9 read clears", timeoutIrq, 0);

    // random traffic
    for (int n = 0; n < 6000; n++) begin
      charValid = ($urandom_range(99) < 45);
      charData = 8'($urandom);
      charParErr = ($urandom_range(99) < 8);
      charFrmErr = ($urandom_range(99) < 8);
      charBrk = ($urandom_range(99) < 5);
      dataRead = ($urandom_range(99) < 35);
      lsrRead = ($urandom_range(99) < 10);
      charTick = ($urandom_range(99) < 40);
      ctlWrite = ($urandom_range(999) < 8);
      ctlEnable = ($urandom_range(99) < 85);
      ctlFlush = ($urandom_range(99) < 30);
      ctlTrig = 2'($urandom);
      cycle();
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule